// File: doc/BRIEF.md
# Inline-ECC Line Address Remapper

This block turns a host cache-line address (one 64-byte line per request) into a memory controller select and a controller-local line address for a memory that stores its error-correction codes inline. Device memory is divided into groups of 64 lines. With ECC enabled, only the first 62 lines of a group hold data and the last two hold that group's check bits. The host sees a dense data space with no holes. The remapper divides the host line by 62 to find the group and the offset, sends the group to a controller through a fixed permutation, and returns the data line and the ECC line of that group inside the chosen controller.

The divide is iterative, one quotient bit per cycle. While it runs, the request port is held off, so results come out in request order. With ECC disabled, the division becomes a shift: all 64 lines of a group carry data, and the response follows in the next cycle. Each controller appears here as one logical 64-bit channel, and the block does not decode the lockstep channel pair below it.

Top module: `inline_ecc_remap`

## Requirements
- R1: After reset, req_ready_o is 1 and rsp_valid_o is 0.
- R2: With ECC enabled, let q = line / 62 and r = line % 62. The data line is then (q >> 3) * 64 + r.
- R3: The controller select is PERM[q mod 8]. The default table gives controller (5*k) mod 8 for group index k, so the sequence is 0,5,2,7,4,1,6,3.
- R4: With ECC enabled, the ECC line output is (q >> 3) * 64 + 62, and the group's second check line is the one after it. Bits [5:0] of a data line are never 62 or 63.
- R5: With ECC disabled, q = line >> 6 and r = line[5:0]. The data line is (q >> 3) * 64 + r, the ECC line output is 0, rsp_ecc_o is 0, and rsp_valid_o rises in the cycle after acceptance.
- R6: After an ECC-mode acceptance, req_ready_o is 0 from the next cycle until the response is presented. A request held during that time is accepted only afterwards, and responses keep request order.
- R7: rsp_valid_o is high for a single cycle per accepted request, and rsp_ecc_o is 1 for ECC-mode responses.
- R8: ecc_en_i and req_line_i are sampled only at acceptance. Changing them while a divide is in flight does not change its result.
- R9: Host lines are dense across group edges. With ECC enabled, host line 61 maps to offset 61 of group 0, and host line 62 maps to offset 0 of group 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request can be accepted |
| req_line_i | input | AW | Host cache-line address |
| ecc_en_i | input | 1 | 1 = inline ECC layout, 0 = bypass, all 64 lines data |
| rsp_valid_o | output | 1 | One-cycle response strobe |
| rsp_ecc_o | output | 1 | Response was computed in ECC mode |
| rsp_mc_o | output | MC_W | Selected memory controller |
| rsp_dev_line_o | output | AW | Controller-local data line |
| rsp_ecc_line_o | output | AW | First ECC line of the group (0 in bypass) |

## Verification
The properties assume that a response and a new bypass acceptance may share a cycle only when the request port is ready. They also assume that ecc_en_i is a stable level in the acceptance cycle. The pulse property excludes a bypass acceptance in that same cycle, because that case produces a legal back-to-back strobe. The stimulus drives requests only on the falling edge and drops valid after acceptance. It also scrambles line and mode during a divide, which is legal because the design samples both only at acceptance.

// File: rtl/ecc_remap_pkg.sv
package ecc_remap_pkg;
  localparam int unsigned GRP_W = 6;  // 64 lines per group
  typedef enum logic {ST_IDLE, ST_DIV} remap_st_e;
endpackage

// File: rtl/ecc_div_iter.sv
module ecc_div_iter #(
  parameter int unsigned AW      = 20,
  parameter int unsigned DIVISOR = 62,
  localparam int unsigned RW     = $clog2(DIVISOR),
  localparam int unsigned CW     = $clog2(AW + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] dividend_i,
  output logic          done_o,
  output logic [AW-1:0] quo_o,
  output logic [RW-1:0] rem_o
);
  localparam logic [RW:0] DIV_V = (RW+1)'(DIVISOR);

  logic [AW-1:0] acc_q;
  logic [RW-1:0] rem_q;
  logic [CW-1:0] cnt_q;
  logic          run_q, done_q;
  logic [RW:0]   shift_v, sub_v;
  logic          ge;

  always_comb begin
    shift_v = {rem_q, acc_q[AW-1]};
    ge      = shift_v >= DIV_V;
    sub_v   = shift_v - DIV_V;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      rem_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (start_i) begin
      acc_q  <= dividend_i;
      rem_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b1;
      done_q <= 1'b0;
    end else if (run_q) begin
      acc_q <= {acc_q[AW-2:0], ge};
      rem_q <= ge ? sub_v[RW-1:0] : shift_v[RW-1:0];
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CW'(AW - 1)) begin
        run_q  <= 1'b0;
        done_q <= 1'b1;
      end
    end else begin
      done_q <= 1'b0;
    end
  end

  assign done_o = done_q;
  assign quo_o  = acc_q;
  assign rem_o  = rem_q;
endmodule

// File: rtl/ecc_line_compose.sv
module ecc_line_compose
  import ecc_remap_pkg::*;
#(
  parameter int unsigned AW         = 20,
  parameter int unsigned NUM_MC     = 8,
  parameter int unsigned DATA_LINES = 62,
  parameter logic [NUM_MC*$clog2(NUM_MC)-1:0] PERM = '0,
  localparam int unsigned MC_W      = $clog2(NUM_MC)
) (
  input  logic [AW-1:0]    quo_i,
  input  logic [GRP_W-1:0] ofs_i,
  input  logic             ecc_i,
  output logic [MC_W-1:0]  mc_o,
  output logic [AW-1:0]    dev_o,
  output logic [AW-1:0]    eccl_o
);
  logic [NUM_MC-1:0][MC_W-1:0] perm_tbl;
  logic [AW-1:0] local_grp, base;

  for (genvar k = 0; k < NUM_MC; k++) begin : g_tbl
    assign perm_tbl[k] = PERM[k*MC_W +: MC_W];
  end

  always_comb begin
    local_grp = quo_i >> MC_W;
    base      = local_grp << GRP_W;
    mc_o      = perm_tbl[quo_i[MC_W-1:0]];
    dev_o     = base | AW'(ofs_i);
    eccl_o    = ecc_i ? (base | AW'(DATA_LINES)) : '0;
  end
endmodule

// File: rtl/inline_ecc_remap.sv
module inline_ecc_remap
  import ecc_remap_pkg::*;
#(
  parameter int unsigned AW         = 20,
  parameter int unsigned NUM_MC     = 8,
  parameter int unsigned DATA_LINES = 62,
  parameter logic [NUM_MC*$clog2(NUM_MC)-1:0] PERM =
    {3'd3, 3'd6, 3'd1, 3'd4, 3'd7, 3'd2, 3'd5, 3'd0},
  localparam int unsigned MC_W      = $clog2(NUM_MC),
  localparam int unsigned RW        = $clog2(DATA_LINES)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_valid_i,
  output logic            req_ready_o,
  input  logic [AW-1:0]   req_line_i,
  input  logic            ecc_en_i,
  output logic            rsp_valid_o,
  output logic            rsp_ecc_o,
  output logic [MC_W-1:0] rsp_mc_o,
  output logic [AW-1:0]   rsp_dev_line_o,
  output logic [AW-1:0]   rsp_ecc_line_o
);
  remap_st_e st_q;
  logic fire, div_start, div_done, load_out, use_div;
  logic [AW-1:0]    div_quo, cmp_quo, c_dev, c_eccl;
  logic [RW-1:0]    div_rem;
  logic [GRP_W-1:0] cmp_ofs;
  logic [MC_W-1:0]  c_mc;

  assign req_ready_o = (st_q == ST_IDLE);
  assign fire        = req_valid_i && req_ready_o;
  assign div_start   = fire && ecc_en_i;
  assign use_div     = (st_q == ST_DIV);
  assign load_out    = (fire && !ecc_en_i) || (use_div && div_done);

  ecc_div_iter #(.AW(AW), .DIVISOR(DATA_LINES)) u_div (
    .clk_i, .rst_ni,
    .start_i(div_start), .dividend_i(req_line_i),
    .done_o(div_done), .quo_o(div_quo), .rem_o(div_rem)
  );

  // bypass: group is a plain shift
  always_comb begin
    if (use_div) begin
      cmp_quo = div_quo;
      cmp_ofs = GRP_W'(div_rem);
    end else begin
      cmp_quo = req_line_i >> GRP_W;
      cmp_ofs = req_line_i[GRP_W-1:0];
    end
  end

  ecc_line_compose #(.AW(AW), .NUM_MC(NUM_MC), .DATA_LINES(DATA_LINES), .PERM(PERM)) u_cmp (
    .quo_i(cmp_quo), .ofs_i(cmp_ofs), .ecc_i(use_div),
    .mc_o(c_mc), .dev_o(c_dev), .eccl_o(c_eccl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE;
    end else if (div_start) begin
      st_q <= ST_DIV;
    end else if (use_div && div_done) begin
      st_q <= ST_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o    <= 1'b0;
      rsp_ecc_o      <= 1'b0;
      rsp_mc_o       <= '0;
      rsp_dev_line_o <= '0;
      rsp_ecc_line_o <= '0;
    end else begin
      rsp_valid_o <= load_out;
      if (load_out) begin
        rsp_ecc_o      <= use_div;
        rsp_mc_o       <= c_mc;
        rsp_dev_line_o <= c_dev;
        rsp_ecc_line_o <= c_eccl;
      end
    end
  end
endmodule

// File: rtl/inline_ecc_remap_chk.sv
module inline_ecc_remap_chk #(
  parameter int unsigned AW = 20
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_valid_i,
  input logic          req_ready_o,
  input logic          ecc_en_i,
  input logic          rsp_valid_o,
  input logic          rsp_ecc_o,
  input logic [AW-1:0] rsp_dev_line_o,
  input logic [AW-1:0] rsp_ecc_line_o
);
  logic acc_byp;
  assign acc_byp = req_valid_i && req_ready_o && !ecc_en_i;

  p_ready_drop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o && ecc_en_i |=> !req_ready_o);

  p_bypass_next_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_byp |=> rsp_valid_o && !rsp_ecc_o);

  p_no_hole_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_ecc_o |-> rsp_dev_line_o[5:0] < 6'd62);

  p_ecc_same_grp_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_ecc_o |->
      (rsp_ecc_line_o[AW-1:6] == rsp_dev_line_o[AW-1:6]) && (rsp_ecc_line_o[5:0] == 6'd62));

  p_ecc_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ecc_o |-> rsp_ecc_line_o == '0);

  p_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_ecc_o && !acc_byp |=> !rsp_valid_o);
endmodule

bind inline_ecc_remap inline_ecc_remap_chk #(.AW(AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
  .ecc_en_i(ecc_en_i), .rsp_valid_o(rsp_valid_o), .rsp_ecc_o(rsp_ecc_o),
  .rsp_dev_line_o(rsp_dev_line_o), .rsp_ecc_line_o(rsp_ecc_line_o)
);

// File: tb/inline_ecc_remap_bench.sv
module inline_ecc_remap_bench;
  localparam int unsigned AW = 20;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req_valid_i = 1'b0, ecc_en_i = 1'b0;
  logic [AW-1:0] req_line_i = '0;
  logic req_ready_o, rsp_valid_o, rsp_ecc_o;
  logic [2:0] rsp_mc_o;
  logic [AW-1:0] rsp_dev_line_o, rsp_ecc_line_o;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  inline_ecc_remap u_inline_ecc_remap (
    .clk_i(clk), .rst_ni, .req_valid_i, .req_ready_o, .req_line_i, .ecc_en_i,
    .rsp_valid_o, .rsp_ecc_o, .rsp_mc_o, .rsp_dev_line_o, .rsp_ecc_line_o
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // accept a request; returns with the negedge after acceptance
  task automatic issue(input int line, input bit ecc);
    @(negedge clk);
    req_valid_i = 1'b1; req_line_i = AW'(line); ecc_en_i = ecc;
    while (!req_ready_o) @(negedge clk);
    @(negedge clk);
    req_valid_i = 1'b0;
  endtask

  task automatic wait_rsp(input string tag);
    int n = 0;
    while (!rsp_valid_o && n < 100) begin @(negedge clk); n++; end
    chk(rsp_valid_o, tag, rsp_valid_o, 1);
  endtask

  task automatic expect_rsp(input int line, input bit ecc);
    int q, r, lg;
    q  = ecc ? line / 62 : line / 64;
    r  = ecc ? line % 62 : line % 64;
    lg = q / 8;
    chk(rsp_ecc_o == ecc, "R7 ecc flag", rsp_ecc_o, ecc);
    chk(rsp_dev_line_o == AW'(lg*64 + r), ecc ? "R2 dev line" : "R5 dev line", rsp_dev_line_o, lg*64 + r);
    chk(rsp_mc_o == 3'((5*(q%8))%8), "R3 controller", rsp_mc_o, (5*(q%8))%8);
    if (ecc) begin
      chk(rsp_ecc_line_o == AW'(lg*64 + 62), "R4 ecc line", rsp_ecc_line_o, lg*64 + 62);
      chk(rsp_dev_line_o[5:0] < 62, "R4 no hole", rsp_dev_line_o[5:0], 61);
    end else begin
      chk(rsp_ecc_line_o == 0, "R5 ecc line zero", rsp_ecc_line_o, 0);
    end
    @(negedge clk);
    chk(!rsp_valid_o, "R7 single pulse", rsp_valid_o, 0);
  endtask

  task automatic t_reset();
    chk(req_ready_o == 1'b1, "R1 ready", req_ready_o, 1);
    chk(rsp_valid_o == 1'b0, "R1 valid", rsp_valid_o, 0);
  endtask

  task automatic run_ecc(input int line);
    issue(line, 1'b1);
    chk(!req_ready_o, "R6 ready low", req_ready_o, 0);
    wait_rsp("R2 response");
    expect_rsp(line, 1'b1);
  endtask

  task automatic run_byp(input int line);
    issue(line, 1'b0);
    chk(rsp_valid_o, "R5 next cycle", rsp_valid_o, 1);
    expect_rsp(line, 1'b0);
  endtask

  task automatic t_ecc_patterns();
    int pats[8] = '{0, 63, 123, 124, 496, 1000, 31000, 1048575};
    foreach (pats[i]) run_ecc(pats[i]);
  endtask

  task automatic t_perm_walk();  // R3: consecutive groups 0..8
    for (int g = 0; g < 9; g++) run_ecc(g*62 + 5);
  endtask

  task automatic t_bypass();
    int pats[5] = '{0, 62, 63, 64, 1048575};
    foreach (pats[i]) run_byp(pats[i]);
  endtask

  task automatic t_dense_edge();  // R9
    run_ecc(61);
    run_ecc(62);
  endtask

  task automatic t_sample_once();  // R8
    issue(777, 1'b1);
    req_line_i = AW'(5); ecc_en_i = 1'b0;
    wait_rsp("R8 response");
    expect_rsp(777, 1'b1);
  endtask

  task automatic t_held_off();  // R6 ordering
    int n = 0;
    issue(5000, 1'b1);
    req_valid_i = 1'b1; req_line_i = AW'(200); ecc_en_i = 1'b0;
    while (!rsp_valid_o && n < 100) begin
      chk(!req_ready_o, "R6 held off", req_ready_o, 0);
      @(negedge clk); n++;
    end
    chk(rsp_valid_o && rsp_ecc_o, "R6 first in order", rsp_ecc_o, 1);
    chk(rsp_dev_line_o == AW'((5000/62/8)*64 + 5000%62), "R6 first result", rsp_dev_line_o,
        (5000/62/8)*64 + 5000%62);
    @(negedge clk);  // second accepted at the edge with the first response
    req_valid_i = 1'b0;
    chk(rsp_valid_o && !rsp_ecc_o, "R6 second follows", rsp_valid_o, 1);
    expect_rsp(200, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_ecc_patterns();
    t_perm_walk();
    t_bypass();
    t_dense_edge();
    t_sample_once();
    t_held_off();
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin @(posedge clk); cyc++; end
    if (!done) chk(1'b0, "watchdog", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule